// File: doc/BRIEF.md
# Legacy Memory Attribute Decoder

This block owns the chipset settings that decide where accesses to the legacy address window (0xA0000 up to 0xFFFFF) are sent. Software programs shadow attributes and the system-management RAM control through byte-wide configuration writes. An input from the processor says whether system-management mode is active. For each memory access presented on the access port, the block answers one cycle later with a single routing bit: main DRAM, or the legacy/PCI path.

The window has three parts. The 128 KB video area at 0xA0000–0xBFFFF opens to DRAM only under the SMRAM control. Twelve 16 KB expansion segments cover 0xC0000–0xEFFFF. One 64 KB segment covers 0xF0000–0xFFFFF. Each segment carries a 2-bit attribute that routes reads and writes separately. A read port returns the programmed bytes and also returns a read-only byte that gives the installed memory size in 8 MB units.

The video-area routing is held in a small state machine with three states. `WIN_LEGACY` means the area goes to the legacy path. `WIN_SMM_OPEN` means it is open because SMM is active and the SMM-open bit is set. `WIN_FORCED_OPEN` means the force-open bit is set. On every clock the machine takes its next state from the SMRAM byte as it will be after this edge and from the sampled SMM input. The transitions have these names: `open_force` goes to `WIN_FORCED_OPEN` whenever bit 6 is set. `open_smm` goes to `WIN_SMM_OPEN` when bit 6 is clear and both bit 3 and SMM are set. `close` goes to `WIN_LEGACY` otherwise.

Top module: `legacy_mem_decoder`

## Requirements
- R1: After reset the seven attribute bytes (offsets 0x59–0x5F) read 0x00, the SMRAM control byte (offset 0x72) reads 0x02, and `resp_valid` is low.
- R2: An access presented with `acc_valid` high produces `resp_valid` high on the following cycle together with its routing bit. A cycle without `acc_valid` produces no response on the following cycle.
- R3: The top segment 0xF0000–0xFFFFF takes its attribute from bits [5:4] of offset 0x59. The other bits of that byte do not affect routing.
- R4: The 16 KB segment i (i = 0..11, base 0xC0000 + i·0x4000) takes its attribute from offset 0x5A + (i>>1). An even i uses bits [1:0] of that byte and an odd i uses bits [5:4]. Bits 3:2 and 7:6 do not affect routing.
- R5: Attribute bit 0 set routes reads to DRAM and attribute bit 1 set routes writes to DRAM. A clear bit routes that direction to the legacy path. So 00 = both legacy, 01 = reads to DRAM, 10 = writes to DRAM, 11 = both to DRAM. `resp_to_dram` is 1 for DRAM and 0 for the legacy path.
- R6: Reads and writes to 0xA0000–0xBFFFF go to DRAM when SMRAM bit 6 is set, or when SMRAM bit 3 and `smm_active` are both set. Otherwise they go to the legacy path.
- R7: A configuration write or a change of `smm_active` seen at one clock edge governs an access presented in the next cycle. An access presented in the same cycle as a write is decoded with the old value.
- R8: Addresses below 0xA0000 and at or above 0x100000 always route to DRAM.
- R9: Offset 0x57 reads floor(`dram_mb`/8), saturated at 255. Writes to it are ignored.
- R10: Offsets other than 0x57, 0x59–0x5F and 0x72 read 0x00. Writes to them change neither routing nor any readable byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration byte write strobe |
| cfg_wr_ofs | input | 8 | Configuration byte offset for the write |
| cfg_wr_data | input | 8 | Configuration byte value |
| cfg_rd_ofs | input | 8 | Configuration byte offset for the read |
| cfg_rd_data | output | 8 | Byte at `cfg_rd_ofs` (combinational) |
| dram_mb | input | MB_W | Installed DRAM in megabytes |
| smm_active | input | 1 | System-management mode is active |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | ADDR_W | Access byte address |
| acc_write | input | 1 | 1 = write access, 0 = read access |
| resp_valid | output | 1 | Routing answer valid (one cycle after the access) |
| resp_to_dram | output | 1 | 1 = DRAM, 0 = legacy path |

## Verification
The bench sets up each attribute byte with junk in the bits that should be ignored. A decoder that picked the wrong nibble, or took the wrong pair of bits, would then mis-route the odd segments or the top segment. It probes the first and last byte of segments and the window edges at 0x9FFFF, 0xA0000, 0xBFFFF and 0x100000, where an off-by-one range compare would route the wrong way. It sends a write and an access in the same cycle to show that a design which forwarded new values, or delayed them by a cycle, would break the one-cycle visibility rule. It also toggles SMM with the SMM-open bit set and clear, and drives the memory-size input across the saturation point, where a truncating design would wrap instead of holding at 255.

// File: rtl/lmd_pkg.sv
package lmd_pkg;

    // Configuration offsets the decoder owns
    localparam logic [7:0] OFS_RAM_SIZE  = 8'h57;
    localparam logic [7:0] OFS_ATTR_TOP  = 8'h59;
    localparam logic [7:0] OFS_ATTR_LAST = 8'h5F;
    localparam logic [7:0] OFS_SMRAM     = 8'h72;
    localparam logic [7:0] SMRAM_RESET   = 8'h02;
    localparam int         ATTR_BYTES    = 7;

    // SMRAM control bit positions
    localparam int SMRAM_SMM_OPEN_BIT   = 3;
    localparam int SMRAM_FORCE_OPEN_BIT = 6;

    typedef logic [ATTR_BYTES-1:0][7:0] attr_bank_t;

    typedef enum logic [1:0] {
        WIN_LEGACY      = 2'd0,
        WIN_SMM_OPEN    = 2'd1,
        WIN_FORCED_OPEN = 2'd2
    } win_state_e;

endpackage

// File: rtl/lmd_cfg_regs.sv
module lmd_cfg_regs
    import lmd_pkg::*;
#(
    parameter int MB_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [7:0]      wr_ofs,
    input  logic [7:0]      wr_data,
    input  logic [7:0]      rd_ofs,
    input  logic [MB_W-1:0] dram_mb,
    output logic [7:0]      rd_data,
    output attr_bank_t      attr_q,
    output logic [7:0]      smram_q,
    output logic [7:0]      smram_d
);
    localparam int UNITS_W = MB_W - 3;

    // One register per attribute byte
    for (genvar g = 0; g < ATTR_BYTES; g++) begin : g_attr
        localparam logic [7:0] MY_OFS = OFS_ATTR_TOP + 8'(g);
        always_ff @(posedge clk) begin
            if (!rst_n)
                attr_q[g] <= 8'h00;
            else if (wr_en && wr_ofs == MY_OFS)
                attr_q[g] <= wr_data;
        end
    end

    // Value of the SMRAM byte once this edge has passed
    always_comb begin
        smram_d = smram_q;
        if (wr_en && wr_ofs == OFS_SMRAM)
            smram_d = wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            smram_q <= SMRAM_RESET;
        else
            smram_q <= smram_d;
    end

    // Memory size in 8 MB units, held at 255
    logic [UNITS_W-1:0] units;
    logic [7:0]         size_byte;
    always_comb begin
        units = dram_mb[MB_W-1:3];
        if (units > UNITS_W'(255))
            size_byte = 8'hFF;
        else
            size_byte = units[7:0];
    end

    always_comb begin
        rd_data = 8'h00;
        if (rd_ofs == OFS_RAM_SIZE)
            rd_data = size_byte;
        else if (rd_ofs == OFS_SMRAM)
            rd_data = smram_q;
        else if (rd_ofs >= OFS_ATTR_TOP && rd_ofs <= OFS_ATTR_LAST)
            rd_data = attr_q[3'(rd_ofs - OFS_ATTR_TOP)];
    end

endmodule

// File: rtl/lmd_window_fsm.sv
module lmd_window_fsm
    import lmd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] smram_d,
    input  logic       smm_active,
    output logic       win_open
);
    win_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WIN_LEGACY, WIN_SMM_OPEN, WIN_FORCED_OPEN: begin
                if (smram_d[SMRAM_FORCE_OPEN_BIT])
                    state_d = WIN_FORCED_OPEN;              // open_force
                else if (smram_d[SMRAM_SMM_OPEN_BIT] && smm_active)
                    state_d = WIN_SMM_OPEN;                 // open_smm
                else
                    state_d = WIN_LEGACY;                   // close
            end
            default: state_d = WIN_LEGACY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= WIN_LEGACY;
        else
            state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            WIN_LEGACY:      win_open = 1'b0;
            WIN_SMM_OPEN:    win_open = 1'b1;
            WIN_FORCED_OPEN: win_open = 1'b1;
            default:         win_open = 1'b0;
        endcase
    end

endmodule

// File: rtl/lmd_route.sv
module lmd_route
    import lmd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  attr_bank_t        attr_q,
    input  logic              win_open,
    output logic              resp_valid,
    output logic              resp_to_dram
);
    localparam int HI_W = ADDR_W - 20;

    logic       below_1m;
    logic       in_video, in_seg16, in_top;
    logic [5:0] seg_raw;
    logic [3:0] seg;
    logic [7:0] seg_byte;
    logic [1:0] attr;
    logic       to_dram;

    always_comb begin
        below_1m = (acc_addr[ADDR_W-1:20] == HI_W'(0));
        in_video = below_1m && (acc_addr[19:17] == 3'b101);
        in_seg16 = below_1m && (acc_addr[19:18] == 2'b11) && (acc_addr[17:16] != 2'b11);
        in_top   = below_1m && (acc_addr[19:16] == 4'hF);

        seg_raw  = acc_addr[19:14] - 6'd48;
        seg      = seg_raw[3:0];
        seg_byte = attr_q[3'd1 + 3'(seg[3:1])];

        if (in_top)
            attr = attr_q[0][5:4];
        else if (seg[0])
            attr = seg_byte[5:4];
        else
            attr = seg_byte[1:0];

        if (in_video)
            to_dram = win_open;
        else if (in_seg16 || in_top)
            to_dram = acc_write ? attr[1] : attr[0];
        else
            to_dram = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid   <= 1'b0;
            resp_to_dram <= 1'b0;
        end else begin
            resp_valid   <= acc_valid;
            resp_to_dram <= acc_valid ? to_dram : 1'b0;
        end
    end

endmodule

// File: rtl/legacy_mem_decoder.sv
module legacy_mem_decoder
    import lmd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int MB_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [7:0]        cfg_wr_ofs,
    input  logic [7:0]        cfg_wr_data,
    input  logic [7:0]        cfg_rd_ofs,
    output logic [7:0]        cfg_rd_data,
    input  logic [MB_W-1:0]   dram_mb,
    input  logic              smm_active,
    input  logic              acc_valid,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    output logic              resp_valid,
    output logic              resp_to_dram
);
    attr_bank_t attr_q;
    logic [7:0] smram_q, smram_d;
    logic       win_open;

    lmd_cfg_regs #(.MB_W(MB_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_ofs  (cfg_wr_ofs),
        .wr_data (cfg_wr_data),
        .rd_ofs  (cfg_rd_ofs),
        .dram_mb (dram_mb),
        .rd_data (cfg_rd_data),
        .attr_q  (attr_q),
        .smram_q (smram_q),
        .smram_d (smram_d)
    );

    lmd_window_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .smram_d    (smram_d),
        .smm_active (smm_active),
        .win_open   (win_open)
    );

    lmd_route #(.ADDR_W(ADDR_W)) u_route (
        .clk          (clk),
        .rst_n        (rst_n),
        .acc_valid    (acc_valid),
        .acc_addr     (acc_addr),
        .acc_write    (acc_write),
        .attr_q       (attr_q),
        .win_open     (win_open),
        .resp_valid   (resp_valid),
        .resp_to_dram (resp_to_dram)
    );

endmodule

// File: rtl/lmd_checker.sv
module lmd_checker #(
    parameter int ADDR_W = 32,
    parameter int MB_W   = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic [7:0]        cfg_wr_ofs,
    input logic [7:0]        cfg_wr_data,
    input logic [7:0]        cfg_rd_ofs,
    input logic [7:0]        cfg_rd_data,
    input logic [MB_W-1:0]   dram_mb,
    input logic              smm_active,
    input logic              acc_valid,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              acc_write,
    input logic              resp_valid,
    input logic              resp_to_dram
);
    logic outside, in_video;
    assign outside  = (acc_addr < ADDR_W'(32'hA0000)) || (acc_addr >= ADDR_W'(32'h100000));
    assign in_video = (acc_addr >= ADDR_W'(32'hA0000)) && (acc_addr < ADDR_W'(32'hC0000));

    // R2: every access is answered on the next cycle
    p_answer_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |=> resp_valid);

    // R2: no answer without an access
    p_quiet_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !resp_valid);

    // R8: outside the window always DRAM
    p_outside_dram_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && outside) |=> resp_to_dram);

    // R6: force-open bit visible on the read port sends the video area to DRAM
    p_forced_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && in_video && cfg_rd_ofs == 8'h72 && cfg_rd_data[6]) |=> resp_to_dram);

    // R9: size byte saturates
    p_size_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rd_ofs == 8'h57 && dram_mb >= MB_W'(2040)) |-> cfg_rd_data == 8'hFF);

endmodule

bind legacy_mem_decoder lmd_checker #(.ADDR_W(ADDR_W), .MB_W(MB_W)) u_chk (.*);

// File: tb/legacy_mem_decoder_test.sv
module legacy_mem_decoder_test;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    typedef struct packed {
        logic [31:0] addr;
        logic        wr;
        logic        exp;
    } vec_t;

    // Routing table after the programming below (R3, R4, R5, R6, R8)
    localparam int NVEC = 20;
    localparam vec_t VEC [NVEC] = '{
        '{32'h000F0000, 1'b0, 1'b1},  // R3 top seg attr 01 read
        '{32'h000F0000, 1'b1, 1'b0},  // R3 top seg write
        '{32'h000FFFFF, 1'b0, 1'b1},  // R3 last byte
        '{32'h000C0000, 1'b0, 1'b0},  // R4 seg0 attr 10 read
        '{32'h000C3FFF, 1'b1, 1'b1},  // R4 seg0 write
        '{32'h000C4000, 1'b0, 1'b1},  // R4 seg1 attr 11 read
        '{32'h000C7FFF, 1'b1, 1'b1},  // R4 seg1 write
        '{32'h000C8000, 1'b0, 1'b1},  // R5 seg2 attr 01 read
        '{32'h000C8000, 1'b1, 1'b0},  // R5 seg2 write
        '{32'h000CC000, 1'b0, 1'b0},  // R4 seg3 high nibble 0xC -> 00
        '{32'h000CC000, 1'b1, 1'b0},  // R4 seg3 write
        '{32'h000D0000, 1'b0, 1'b0},  // R5 seg4 00
        '{32'h000E8000, 1'b0, 1'b0},  // R4 seg10 00
        '{32'h000EC000, 1'b1, 1'b1},  // R4 seg11 attr 10 write
        '{32'h000EFFFF, 1'b0, 1'b0},  // R4 seg11 read
        '{32'h000A0000, 1'b0, 1'b0},  // R6 video legacy
        '{32'h000BFFFF, 1'b1, 1'b0},  // R6 video legacy write
        '{32'h0009FFFF, 1'b0, 1'b1},  // R8 below window
        '{32'h00100000, 1'b1, 1'b1},  // R8 above window
        '{32'h00000000, 1'b0, 1'b1}   // R8 zero
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_wr_ofs = '0;
    logic [7:0]  cfg_wr_data = '0;
    logic [7:0]  cfg_rd_ofs = '0;
    logic [7:0]  cfg_rd_data;
    logic [15:0] dram_mb = 16'd128;
    logic        smm_active = 1'b0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic        resp_valid;
    logic        resp_to_dram;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    legacy_mem_decoder uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_wr_en    (cfg_wr_en),
        .cfg_wr_ofs   (cfg_wr_ofs),
        .cfg_wr_data  (cfg_wr_data),
        .cfg_rd_ofs   (cfg_rd_ofs),
        .cfg_rd_data  (cfg_rd_data),
        .dram_mb      (dram_mb),
        .smm_active   (smm_active),
        .acc_valid    (acc_valid),
        .acc_addr     (acc_addr),
        .acc_write    (acc_write),
        .resp_valid   (resp_valid),
        .resp_to_dram (resp_to_dram)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cfg_write(input logic [7:0] ofs, input logic [7:0] val);
        cfg_wr_en = 1'b1; cfg_wr_ofs = ofs; cfg_wr_data = val;
        @(negedge clk);
        cfg_wr_en = 1'b0;
    endtask

    task automatic read_byte(input string req, input logic [7:0] ofs, input logic [7:0] exp);
        cfg_rd_ofs = ofs;
        #1;
        check(req, {24'h0, cfg_rd_data}, {24'h0, exp});
    endtask

    // Present one access, then sample the answer one cycle later
    task automatic access(input string req, input logic [31:0] a, input logic wr, input logic exp);
        acc_valid = 1'b1; acc_addr = a; acc_write = wr;
        @(negedge clk);
        acc_valid = 1'b0;
        check({req, " valid"}, {31'h0, resp_valid}, 32'h1);
        check(req, {31'h0, resp_to_dram}, {31'h0, exp});
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 resp_valid", {31'h0, resp_valid}, 32'h0);
        for (int i = 0; i < 7; i++) read_byte("R1 attr byte", 8'h59 + 8'(i), 8'h00);
        read_byte("R1 smram", 8'h72, 8'h02);

        // R2 idle cycle gives no answer
        @(negedge clk);
        check("R2 idle", {31'h0, resp_valid}, 32'h0);

        // Program with junk in the ignored bits (R3, R4)
        cfg_write(8'h59, 8'hD0);
        cfg_write(8'h5A, 8'h3E);
        cfg_write(8'h5B, 8'hC1);
        cfg_write(8'h5F, 8'h24);
        read_byte("R3 readback", 8'h59, 8'hD0);
        read_byte("R4 readback", 8'h5B, 8'hC1);

        for (int v = 0; v < NVEC; v++)
            access($sformatf("vector %0d R3/R4/R5/R6/R8", v), VEC[v].addr, VEC[v].wr, VEC[v].exp);

        // R7 write and access in the same cycle: old value, then new
        acc_valid = 1'b1; acc_addr = 32'hF0000; acc_write = 1'b0;
        cfg_wr_en = 1'b1; cfg_wr_ofs = 8'h59; cfg_wr_data = 8'h00;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        check("R7 same-cycle old value", {31'h0, resp_to_dram}, 32'h1);
        access("R7 next-cycle new value", 32'hF0000, 1'b0, 1'b0);

        // R6 SMM-gated opening
        cfg_write(8'h72, 8'h0A);
        access("R6 bit3 without SMM", 32'hA0000, 1'b0, 1'b0);
        smm_active = 1'b1;
        @(negedge clk);
        access("R6 R7 bit3 with SMM", 32'hB0000, 1'b1, 1'b1);
        smm_active = 1'b0;
        @(negedge clk);
        access("R6 SMM dropped", 32'hA0000, 1'b0, 1'b0);
        cfg_write(8'h72, 8'h00);
        smm_active = 1'b1;
        @(negedge clk);
        access("R6 SMM without bit3", 32'hA0000, 1'b0, 1'b0);
        smm_active = 1'b0;
        cfg_write(8'h72, 8'h40);
        access("R6 force open", 32'hBFFFF, 1'b0, 1'b1);
        read_byte("R6 smram readback", 8'h72, 8'h40);

        // R9 memory size byte
        dram_mb = 16'd128;  read_byte("R9 128MB", 8'h57, 8'd16);
        dram_mb = 16'd2039; read_byte("R9 2039MB", 8'h57, 8'd254);
        dram_mb = 16'd2040; read_byte("R9 2040MB", 8'h57, 8'd255);
        dram_mb = 16'd4000; read_byte("R9 saturate", 8'h57, 8'd255);
        cfg_write(8'h57, 8'h12);
        read_byte("R9 write ignored", 8'h57, 8'd255);

        // R10 unowned offsets
        cfg_write(8'h58, 8'hFF);
        cfg_write(8'h60, 8'hFF);
        read_byte("R10 offset 58", 8'h58, 8'h00);
        read_byte("R10 offset 60", 8'h60, 8'h00);
        access("R10 routing untouched", 32'hE8000, 1'b0, 1'b0);

        // R1 reset again restores defaults
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        read_byte("R1 smram after reset", 8'h72, 8'h02);
        read_byte("R1 attr after reset", 8'h5A, 8'h00);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule